// File: doc/BRIEF.md
# Burst SRAM Access Cycle Controller

This block is the synchronous front end of a flow-through burst SRAM whose data port is shared between reads and writes. At every rising clock edge it samples three chip enables, a processor address strobe, a controller address strobe, an advance input and the global and per-byte write controls. From these it sorts the cycle into one of four kinds: a deselect, the start of a read or write burst, a step to the next burst address, or a hold at the current one. It then loads the address register, drives per-lane write enables into a behavioural word array and decides whether the read data may be driven.

Read data leaves the array combinationally from the registered address, so it is valid in the cycle after the sampling edge. A two-bit counter walks the low address bits in linear or interleaved order. The common I/O is modelled as a data-out bus with a separate drive-enable. A sleep input, synchronised inside the block, freezes all activity without losing array contents. After wake-up, a short recovery window flags any early attempt to select the device.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A cycle in which a strobe is honoured but the device is not selected (selected means ce1_n=0, ce2=1, ce3_n=0) is a deselect. It writes nothing, turns dout_en off in the following cycle and ends any burst.
- R2: When both strobes are low and ce1_n=0, only the processor strobe is honoured, so the cycle is a read even if the write controls request a write.
- R3: With ce1_n=1 the processor strobe is ignored. If the controller strobe is also high, the cycle acts as a continue or hold of the current burst.
- R4: A burst started by the processor strobe is always a read. Write controls sampled in that cycle have no effect.
- R5: A burst started by the controller strobe (processor strobe not honoured) writes din to the presented address when the write controls request a write. Otherwise it reads that address.
- R6: With no strobe and an active burst, adv_n=0 moves to the next address and adv_n=1 keeps the current one. The write controls choose read or write. The beat k low bits are (start+k) mod 4 when interleave=0 and start XOR k when interleave=1, with the mode latched at burst start. The bits above bit 1 never change, and the fifth beat wraps to the start.
- R7: gw_n=0 writes all lanes. Otherwise, with bwe_n=0, each bsel_n[i]=0 writes lane i (bits 8i+7:8i) and the other lanes keep their contents. With bwe_n=1 and gw_n=1 nothing is written.
- R8: After a read cycle, dout equals the word at the new registered address in that same cycle. dout_en=1 exactly when oe_n=0 and the last cycle was a read. A write cycle forces dout_en=0, and dout reads 0 whenever dout_en=0.
- R9: Once sleep has been seen high on two edges, every cycle is ignored (no write, dout_en=0) and the burst ends. Array contents are kept.
- R10: After sleep has been seen low on two edges, the next two cycles are also ignored. An active strobe or chip enable (ce1_n=0, ce2=1 or ce3_n=0) in either of them sets proto_err for the following cycle. Otherwise proto_err stays 0.
- R11: A continue or hold cycle with no active burst (after reset or a deselect) accesses nothing and leaves dout_en=0.
- R12: During and right after reset, dout_en=0 and proto_err=0, and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep | input | 1 | Asynchronous low-power request, active high |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | BYTES | Per-lane byte select, active low |
| addr | input | ADDR_W | Word address |
| din | input | BYTES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | BYTES*LANE_W | Flow-through read data, 0 when not driven |
| dout_en | output | 1 | Data bus drive enable |
| proto_err | output | 1 | Recovery-window violation pulse |

## Verification
The bench builds the block with a 64-word array of four 8-bit lanes, two synchroniser stages and a two-cycle recovery window. With an array that small, bursts from every start offset in both orders can be written and read back across all four beats, including the hold and the wrap. All sixteen byte-select masks are applied at one address and compared lane by lane. The short sleep and recovery settings let the bench count the exact cycle where activity stops, where it resumes, and where a violation is reported.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of beat cnt from start offset
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/cycle_decode.sv
module cycle_decode
  import burst_sram_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             blk_i,
  input  logic             active_i,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             strobe_p_n,
  input  logic             strobe_c_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [BYTES-1:0] bsel_n,
  output logic             begin_o,
  output logic             deselect_o,
  output logic             advance_o,
  output op_e              op_o,
  output logic [BYTES-1:0] lane_we_o
);

  logic             p_take;
  logic             c_take;
  logic             sel;
  logic             wr_req;
  logic [BYTES-1:0] lane_mask;

  assign p_take = !strobe_p_n && !ce1_n;
  assign c_take = !strobe_c_n && !p_take;
  assign sel    = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    if (!gw_n)       lane_mask = '1;
    else if (!bwe_n) lane_mask = ~bsel_n;
    else             lane_mask = '0;
  end

  assign wr_req = |lane_mask;

  always_comb begin
    begin_o    = 1'b0;
    deselect_o = 1'b0;
    advance_o  = 1'b0;
    op_o       = OP_IDLE;
    if (blk_i) begin
      op_o = OP_IDLE;
    end else if (p_take || c_take) begin
      if (sel) begin
        begin_o = 1'b1;
        op_o    = (c_take && wr_req) ? OP_WRITE : OP_READ;
      end else begin
        deselect_o = 1'b1;
      end
    end else if (active_i) begin
      advance_o = !adv_n;
      op_o      = wr_req ? OP_WRITE : OP_READ;
    end
  end

  assign lane_we_o = (op_o == OP_WRITE) ? lane_mask : '0;

endmodule

// File: rtl/burst_addr.sv
module burst_addr
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic              advance_i,
  input  logic              end_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              active_o
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              ilv_q, ilv_d;
  logic              active_q, active_d;
  logic              upd_en;
  logic [1:0]        cnt_step;

  assign cnt_step = cnt_q + {1'b0, advance_i};

  always_comb begin
    if (begin_i)
      eff_addr_o = addr_i;
    else
      eff_addr_o = {base_q[ADDR_W-1 -: HI_W], beat_lsb(base_q[1:0], cnt_step, ilv_q)};
  end

  assign cur_addr_o = {base_q[ADDR_W-1 -: HI_W], beat_lsb(base_q[1:0], cnt_q, ilv_q)};
  assign active_o   = active_q;
  assign upd_en     = begin_i || advance_i;

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    ilv_d    = ilv_q;
    active_d = active_q;
    if (begin_i) begin
      base_d   = addr_i;
      cnt_d    = 2'd0;
      ilv_d    = ilv_i;
      active_d = 1'b1;
    end else if (end_i) begin
      active_d = 1'b0;
    end else if (advance_i) begin
      cnt_d = cnt_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (upd_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      ilv_q  <= ilv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic any_act_i,
  output logic blk_o,
  output logic rec_act_o,
  output logic viol_o
);

  localparam int REC_W = $clog2(REC_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [REC_W-1:0]       rec_q, rec_d;
  logic                   viol_q, viol_d;
  logic                   asleep;
  logic                   exit_edge;

  assign sync_d    = {sync_q[SYNC_STAGES-2:0], sleep_i};
  assign asleep    = sync_q[SYNC_STAGES-1];
  assign exit_edge = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES-2];
  assign rec_act_o = (rec_q != '0);
  assign blk_o     = asleep || rec_act_o;

  always_comb begin
    if (exit_edge)      rec_d = REC_W'(REC_CYCLES);
    else if (rec_act_o) rec_d = rec_q - 1'b1;
    else                rec_d = rec_q;
    viol_d = rec_act_o && any_act_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      rec_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      rec_q  <= rec_d;
      viol_q <= viol_d;
    end
  end

  assign viol_o = viol_q;

endmodule

// File: rtl/byte_array.sv
module byte_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [BYTES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [BYTES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [BYTES*LANE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[g]) lane_mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = lane_mem[raddr_i];
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BYTES       = 4,
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYCLES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    adv_n,
  input  logic                    interleave,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [BYTES-1:0]        bsel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*LANE_W-1:0] din,
  input  logic                    oe_n,
  output logic [BYTES*LANE_W-1:0] dout,
  output logic                    dout_en,
  output logic                    proto_err
);

  localparam int DATA_W = BYTES * LANE_W;

  logic              rst_meta, rst_sync_n;
  logic              blk, rec_act, any_act;
  logic              burst_begin, burst_desel, burst_adv, burst_active;
  op_e               op, op_q;
  logic [BYTES-1:0]  lane_we;
  logic [ADDR_W-1:0] eff_addr, cur_addr;
  logic [DATA_W-1:0] rdata;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign any_act = !ce1_n || ce2 || !ce3_n || !strobe_p_n || !strobe_c_n;

  sleep_ctrl #(.SYNC_STAGES(SYNC_STAGES), .REC_CYCLES(REC_CYCLES)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sleep_i   (sleep),
    .any_act_i (any_act),
    .blk_o     (blk),
    .rec_act_o (rec_act),
    .viol_o    (proto_err)
  );

  cycle_decode #(.BYTES(BYTES)) u_decode (
    .blk_i      (blk),
    .active_i   (burst_active),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .adv_n      (adv_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .bsel_n     (bsel_n),
    .begin_o    (burst_begin),
    .deselect_o (burst_desel),
    .advance_o  (burst_adv),
    .op_o       (op),
    .lane_we_o  (lane_we)
  );

  burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .begin_i    (burst_begin),
    .advance_i  (burst_adv),
    .end_i      (burst_desel || blk),
    .ilv_i      (interleave),
    .addr_i     (addr),
    .eff_addr_o (eff_addr),
    .cur_addr_o (cur_addr),
    .active_o   (burst_active)
  );

  byte_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .we_i    (lane_we),
    .waddr_i (eff_addr),
    .wdata_i (din),
    .raddr_i (cur_addr),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) op_q <= OP_IDLE;
    else             op_q <= op;
  end

  assign dout_en = !oe_n && (op_q == OP_READ);
  assign dout    = dout_en ? rdata : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int BYTES = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             strobe_p_n,
  input logic             strobe_c_n,
  input logic             gw_n,
  input logic             blk,
  input logic             rec_act,
  input logic [BYTES-1:0] lane_we,
  input logic             dout_en,
  input logic             proto_err
);

  // R1
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe_c_n && !ce2) |=> !dout_en);

  // R4
  ptrig_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe_p_n && !ce1_n && ce2 && !ce3_n && !blk) |-> (lane_we == '0));

  // R7
  gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!gw_n && (lane_we != '0)) |-> ($countones(lane_we) == BYTES));

  // R8
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lane_we != '0) |=> !dout_en);

  // R9
  sleep_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk |-> (lane_we == '0));

  // R9
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk |=> !dout_en);

  // R10
  viol_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    proto_err |-> $past(rec_act));

endmodule

bind burst_sram_ctrl burst_sram_chk #(.BYTES(BYTES)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ce1_n      (ce1_n),
  .ce2        (ce2),
  .ce3_n      (ce3_n),
  .strobe_p_n (strobe_p_n),
  .strobe_c_n (strobe_c_n),
  .gw_n       (gw_n),
  .blk        (blk),
  .rec_act    (rec_act),
  .lane_we    (lane_we),
  .dout_en    (dout_en),
  .proto_err  (proto_err)
);

// File: tb/burst_sram_ctrl_bench.sv
module burst_sram_ctrl_bench;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n, sleep, ce1_n, ce2, ce3_n, strobe_p_n, strobe_c_n;
  logic          adv_n, interleave, gw_n, bwe_n, oe_n;
  logic [NB-1:0] bsel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en, proto_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [DW-1:0] ref_mem [1<<AW];

  always #2 clk = ~clk;

  burst_sram_ctrl #(.ADDR_W(AW), .BYTES(NB), .LANE_W(8)) u_burst_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .interleave(interleave), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .addr(addr), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en),
    .proto_err(proto_err)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    logic [7:0] b;
    b = {2'b00, a};
    return {b ^ 8'h3C, ~b, b + 8'h51, b};
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                              input int k, input logic m);
    logic [1:0] kk;
    kk = k[1:0];
    return {base[AW-1:2], m ? (base[1:0] ^ kk) : (base[1:0] + kk)};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    strobe_p_n = 1'b1; strobe_c_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    oe_n = 1'b0; din = '0;
  endtask

  task automatic selct();
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic burst_write(input logic [AW-1:0] base, input logic m);
    idle(); selct(); strobe_c_n = 1'b0; gw_n = 1'b0;
    addr = base; interleave = m; din = pat(base);
    step();
    ref_mem[base] = pat(base);
    chk("R5/R8 write start hiz", {31'd0, dout_en}, 32'd0);
    for (int k = 1; k < 4; k++) begin
      logic [AW-1:0] a;
      a = beat_addr(base, k, m);
      idle(); adv_n = 1'b0; gw_n = 1'b0; din = pat(a);
      step();
      ref_mem[a] = pat(a);
      chk("R6/R8 write beat hiz", {31'd0, dout_en}, 32'd0);
    end
  endtask

  task automatic single_read(input logic [AW-1:0] a, input string tag);
    idle(); selct(); strobe_p_n = 1'b0; addr = a; interleave = 1'b0;
    step();
    chk(tag, {31'd0, dout_en}, 32'd1);
    chk(tag, dout, ref_mem[a]);
  endtask

  task automatic burst_read(input logic [AW-1:0] base, input logic m);
    idle(); selct(); strobe_p_n = 1'b0; gw_n = 1'b0; din = '1;
    addr = base; interleave = m;
    step();
    chk("R4 read start en", {31'd0, dout_en}, 32'd1);
    chk("R4 read start data", dout, ref_mem[base]);
    for (int k = 1; k < 4; k++) begin
      idle(); adv_n = 1'b0; interleave = ~m;
      step();
      chk("R6 burst order", dout, ref_mem[beat_addr(base, k, m)]);
    end
    idle(); adv_n = 1'b1;
    step();
    chk("R6 hold", dout, ref_mem[beat_addr(base, 3, m)]);
    idle(); adv_n = 1'b0;
    step();
    chk("R6 wrap", dout, ref_mem[base]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); sleep = 1'b0; interleave = 1'b0; addr = '0; rst_n = 1'b0;
    repeat (3) step();
    // R12
    chk("R12 reset dout_en", {31'd0, dout_en}, 32'd0);
    chk("R12 reset proto_err", {31'd0, proto_err}, 32'd0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R12 after reset dout_en", {31'd0, dout_en}, 32'd0);

    // R11: continue with no burst
    idle(); adv_n = 1'b0;
    step();
    chk("R11 no burst", {31'd0, dout_en}, 32'd0);

    // R5 R6: bursts from every offset, both orders
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        burst_write(AW'((m * 4 + s) * 4 + s), m[0]);
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        burst_read(AW'((m * 4 + s) * 4 + s), m[0]);

    // R7: every byte-select mask at address 40
    idle(); selct(); strobe_c_n = 1'b0; gw_n = 1'b0; addr = 6'd40; din = '1;
    step(); ref_mem[40] = '1;
    for (int bs = 0; bs < 16; bs++) begin
      logic [DW-1:0] d;
      d = (32'(bs) * 32'h01010101) ^ 32'h5A5A5A5A;
      idle(); selct(); strobe_c_n = 1'b0; bwe_n = 1'b0; bsel_n = bs[3:0];
      addr = 6'd40; din = d;
      step();
      for (int i = 0; i < 4; i++)
        if (!bs[i]) ref_mem[40][i*8 +: 8] = d[i*8 +: 8];
      single_read(6'd40, "R7 byte lanes");
    end
    // R7 R5: bwe_n high with selects low is a read
    idle(); selct(); strobe_c_n = 1'b0; bwe_n = 1'b1; bsel_n = '0;
    addr = 6'd40; din = 32'h0;
    step();
    chk("R5 ctrl read en", {31'd0, dout_en}, 32'd1);
    chk("R7 no write w/o bwe", dout, ref_mem[40]);
    // R7: global write overrides
    idle(); selct(); strobe_c_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1;
    addr = 6'd40; din = 32'hC0FFEE11;
    step(); ref_mem[40] = 32'hC0FFEE11;
    single_read(6'd40, "R7 global write");

    // R2: both strobes low -> read, no write
    idle(); selct(); strobe_c_n = 1'b0; gw_n = 1'b0; addr = 6'd41; din = 32'h11112222;
    step(); ref_mem[41] = 32'h11112222;
    idle(); selct(); strobe_c_n = 1'b0; strobe_p_n = 1'b0; gw_n = 1'b0;
    addr = 6'd41; din = 32'hBADBAD00;
    step();
    chk("R2 priority read en", {31'd0, dout_en}, 32'd1);
    chk("R2 priority read data", dout, 32'h11112222);
    single_read(6'd41, "R2 not written");

    // R3: processor strobe ignored with ce1_n high -> continue
    single_read(6'd8, "R3 burst start");
    idle(); ce1_n = 1'b1; strobe_p_n = 1'b0; adv_n = 1'b0; addr = 6'd30;
    step();
    chk("R3 ignored strobe continues", dout, ref_mem[9]);

    // R8: oe_n is asynchronous
    oe_n = 1'b1; #1;
    chk("R8 oe off", {31'd0, dout_en}, 32'd0);
    chk("R8 oe off data", dout, 32'd0);
    oe_n = 1'b0; #1;
    chk("R8 oe on", dout, ref_mem[9]);

    // R1: deselect via ce2, then continue must not write (R11)
    idle(); selct(); strobe_c_n = 1'b0; gw_n = 1'b0; addr = 6'd42; din = 32'h42424242;
    step(); ref_mem[42] = 32'h42424242;
    idle(); ce1_n = 1'b0; strobe_c_n = 1'b0; gw_n = 1'b0; addr = 6'd42; din = 32'hDEAD0001;
    step();
    chk("R1 deselect off", {31'd0, dout_en}, 32'd0);
    idle(); adv_n = 1'b0; gw_n = 1'b0; din = 32'hDEAD0002;
    step();
    chk("R11 no burst after deselect", {31'd0, dout_en}, 32'd0);
    single_read(6'd42, "R1 nothing written");
    single_read(6'd43 - 6'd0, "R11 next word") ;
    idle(); ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b1; strobe_p_n = 1'b0; addr = 6'd42;
    step();
    chk("R1 deselect ce3", {31'd0, dout_en}, 32'd0);

    // R9: sleep
    idle(); sleep = 1'b1;
    step(); step();
    idle(); selct(); strobe_c_n = 1'b0; gw_n = 1'b0; addr = 6'd40; din = 32'hDEADBEEF;
    step();
    chk("R9 asleep write ignored", {31'd0, dout_en}, 32'd0);
    idle(); selct(); strobe_p_n = 1'b0; addr = 6'd40;
    step();
    chk("R9 asleep read ignored", {31'd0, dout_en}, 32'd0);
    // R10: wake with violation
    idle(); sleep = 1'b0;
    step(); step();
    idle(); selct(); strobe_c_n = 1'b0; gw_n = 1'b0; addr = 6'd40; din = 32'h0BAD0BAD;
    step();
    chk("R10 violation flagged", {31'd0, proto_err}, 32'd1);
    chk("R10 window ignored", {31'd0, dout_en}, 32'd0);
    idle();
    step();
    chk("R10 flag one cycle", {31'd0, proto_err}, 32'd0);
    single_read(6'd40, "R9 contents kept");
    // R10: clean sleep and wake
    idle(); sleep = 1'b1; step(); step(); step();
    sleep = 1'b0; step(); step();
    step();
    chk("R10 clean window 1", {31'd0, proto_err}, 32'd0);
    step();
    chk("R10 clean window 2", {31'd0, proto_err}, 32'd0);
    step();
    chk("R10 clean after", {31'd0, proto_err}, 32'd0);
    single_read(6'd41, "R9 active again");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule